// File: doc/BRIEF.md
# Translation Table Base Register Bank

This block holds up to eight 64-bit descriptors for the in-memory tables of an interrupt translation unit. Each descriptor tells the unit where a table lives, how big it is and how to access it. The fields are a valid flag, a two-level flag, inner and outer cache attributes, shareability, a read-only table type, a read-only entry size, a base address, a page size and a page count. A 32-bit memory-mapped bus reads and writes the descriptors as pairs of independent 32-bit words. The block also drives the decoded parameters of every table as flat output vectors, so the table walker can use them directly.

Each field follows its own access rule. The type and entry size come from parameters. Registers that have no table read as zero and drop writes. A reserved page-size code is stored as 64 KB and a reserved shareability code is stored as non-shareable. Parameters can tie off the two-level flag, the outer cache attribute and the shareability field. Every write is dropped while the unit is enabled or is not yet quiescent. The decoded base address follows the page size: with 64 KB pages, the low four address bits of the field become physical address bits 51:48.

Top module: `tbr_bank`

## Requirements
- R1: Register n (0..7) sits at byte offset BASE_OFF + 8n. Bus address bit 2 selects the upper word (1) or the lower word (0). A read of an unaligned address, or of any address outside the 64-byte window, returns zero, and a write there changes nothing.
- R2: A write to one 32-bit word of a register leaves the other word of that register unchanged.
- R3: Type (upper word bits 26:24) and entry size (upper word bits 20:16) are read-only. Type is 001 for register 0, 100 for register 1 when COLL_PRESENT, and 010 for register 2 when VPE_PRESENT. Every other register has type 000. The entry sizes are DEV_ESZ, COLL_ESZ and VPE_ESZ.
- R4: A register with type 000, or with an index at or above NUM_REGS, reads as all zeros, ignores writes, and drives zero on its outputs.
- R5: The lower word holds the address field at bits 31:12, shareability at 11:10, page size at 9:8 and page count at 7:0. A written page-size code 11 is stored and read back as 10. A written shareability code 11 is stored and read back as 00. The outputs never show code 11 for either field.
- R6: Reset clears the valid flag of every register.
- R7: A write is dropped when unit_enable is 1 or unit_quiescent is 0.
- R8: When INDIRECT_EN is 0, the two-level flag (upper word bit 30) reads as zero and ignores writes.
- R9: When FIXED_ATTR is 1, outer cache (upper word bits 23:21) always reads FIXED_OUTER and shareability always reads FIXED_SHARE, whatever is written. The upper word holds valid at bit 31 and inner cache at bits 29:27.
- R10: The decoded base address for 4 KB or 16 KB pages is {4'b0, address field, 12'b0}. For 64 KB pages (code 10) it is {field[3:0], field[35:4], 16'b0}. The field is made of the upper word bits 15:0 above the lower word bits 31:12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one 32-bit word |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| unit_enable | input | 1 | Translation unit enabled; blocks writes |
| unit_quiescent | input | 1 | Translation unit idle; writes allowed only when 1 |
| tbl_valid | output | NUM_REGS | Valid flag per table |
| tbl_indirect | output | NUM_REGS | Two-level flag per table |
| tbl_inner | output | 3*NUM_REGS | Inner cache attribute per table |
| tbl_outer | output | 3*NUM_REGS | Outer cache attribute per table |
| tbl_share | output | 2*NUM_REGS | Shareability per table (folded) |
| tbl_page | output | 2*NUM_REGS | Page size code per table (folded) |
| tbl_pages | output | 8*NUM_REGS | Page count minus one per table |
| tbl_base | output | 52*NUM_REGS | Decoded physical base address per table |

## Verification
A register that holds the wrong value shows up one cycle after the write: the read path and the table outputs both come straight from the stored fields. A wrong decode of the write gate appears as a changed read-back or a changed table output right after a write made while locked. A wrong fold appears as code 11 on the page or shareability outputs. A wrong write index shows up as data in a neighbouring slot, or in an unimplemented slot that should read zero. An error in the 64 KB address remap appears only on tbl_base, so the bench checks tbl_base under both page-size classes.

// File: rtl/tbr_bank.sv
module tbr_bank #(
  parameter int          NUM_REGS     = 8,
  parameter int          ADDR_W       = 16,
  parameter int          BASE_OFF     = 'h100,
  parameter bit          COLL_PRESENT = 1'b1,
  parameter bit          VPE_PRESENT  = 1'b1,
  parameter bit          INDIRECT_EN  = 1'b1,
  parameter bit          FIXED_ATTR   = 1'b0,
  parameter logic [2:0]  FIXED_OUTER  = 3'b000,
  parameter logic [1:0]  FIXED_SHARE  = 2'b00,
  parameter logic [4:0]  DEV_ESZ      = 5'd7,
  parameter logic [4:0]  COLL_ESZ     = 5'd15,
  parameter logic [4:0]  VPE_ESZ      = 5'd31
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wr,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  input  logic                     unit_enable,
  input  logic                     unit_quiescent,
  output logic [NUM_REGS-1:0]      tbl_valid,
  output logic [NUM_REGS-1:0]      tbl_indirect,
  output logic [3*NUM_REGS-1:0]    tbl_inner,
  output logic [3*NUM_REGS-1:0]    tbl_outer,
  output logic [2*NUM_REGS-1:0]    tbl_share,
  output logic [2*NUM_REGS-1:0]    tbl_page,
  output logic [8*NUM_REGS-1:0]    tbl_pages,
  output logic [52*NUM_REGS-1:0]   tbl_base
);
  localparam int SLOTS = 8;
  localparam logic [ADDR_W-7:0] WIN_TAG = (ADDR_W-6)'(BASE_OFF >> 6);

  function automatic logic [2:0] ty_of(int k);
    case (k)
      0:       return 3'b001;
      1:       return COLL_PRESENT ? 3'b100 : 3'b000;
      2:       return VPE_PRESENT  ? 3'b010 : 3'b000;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic [4:0] esz_of(int k);
    case (k)
      0:       return DEV_ESZ;
      1:       return COLL_ESZ;
      2:       return VPE_ESZ;
      default: return 5'd0;
    endcase
  endfunction

  logic        in_win, wr_ok, hi;
  logic [2:0]  sel;
  logic [31:0] rd_word [SLOTS];

  assign in_win    = (bus_addr[ADDR_W-1:6] == WIN_TAG) && (bus_addr[1:0] == 2'b00);
  assign wr_ok     = bus_wr && in_win && !unit_enable && unit_quiescent;
  assign sel       = bus_addr[5:3];
  assign hi        = bus_addr[2];
  assign bus_rdata = in_win ? rd_word[sel] : 32'h0;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    localparam logic [2:0] TY  = ty_of(i);
    localparam logic [4:0] ESZ = esz_of(i);

    if (i < NUM_REGS && TY != 3'b000) begin : g_impl
      logic        valid_q, ind_q, ind_v;
      logic [2:0]  inner_q, outer_q, outer_v;
      logic [35:0] addr_q;
      logic [1:0]  share_q, page_q, share_v;
      logic [7:0]  size_q;
      logic [51:0] base_v;
      logic        hit;

      assign hit = wr_ok && (sel == 3'(i));

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          valid_q <= 1'b0;
          ind_q   <= 1'b0;
          inner_q <= '0;
          outer_q <= '0;
          addr_q  <= '0;
          share_q <= '0;
          page_q  <= '0;
          size_q  <= '0;
        end else if (hit) begin
          if (hi) begin
            valid_q        <= bus_wdata[31];
            ind_q          <= bus_wdata[30];
            inner_q        <= bus_wdata[29:27];
            outer_q        <= bus_wdata[23:21];
            addr_q[35:20]  <= bus_wdata[15:0];
          end else begin
            addr_q[19:0]   <= bus_wdata[31:12];
            share_q        <= (bus_wdata[11:10] == 2'b11) ? 2'b00 : bus_wdata[11:10];
            page_q         <= (bus_wdata[9:8]   == 2'b11) ? 2'b10 : bus_wdata[9:8];
            size_q         <= bus_wdata[7:0];
          end
        end
      end

      assign ind_v   = INDIRECT_EN ? ind_q : 1'b0;
      assign outer_v = FIXED_ATTR ? FIXED_OUTER : outer_q;
      assign share_v = FIXED_ATTR ? FIXED_SHARE : share_q;
      assign base_v  = (page_q == 2'b10) ? {addr_q[3:0], addr_q[35:4], 16'h0}
                                         : {4'h0, addr_q, 12'h0};

      assign rd_word[i] = hi ? {valid_q, ind_v, inner_q, TY, outer_v, ESZ, addr_q[35:20]}
                             : {addr_q[19:0], share_v, page_q, size_q};

      assign tbl_valid[i]          = valid_q;
      assign tbl_indirect[i]       = ind_v;
      assign tbl_inner[3*i +: 3]   = inner_q;
      assign tbl_outer[3*i +: 3]   = outer_v;
      assign tbl_share[2*i +: 2]   = share_v;
      assign tbl_page[2*i +: 2]    = page_q;
      assign tbl_pages[8*i +: 8]   = size_q;
      assign tbl_base[52*i +: 52]  = base_v;
    end else begin : g_none
      assign rd_word[i] = 32'h0;
      if (i < NUM_REGS) begin : g_out
        assign tbl_valid[i]          = 1'b0;
        assign tbl_indirect[i]       = 1'b0;
        assign tbl_inner[3*i +: 3]   = 3'b0;
        assign tbl_outer[3*i +: 3]   = 3'b0;
        assign tbl_share[2*i +: 2]   = 2'b0;
        assign tbl_page[2*i +: 2]    = 2'b0;
        assign tbl_pages[8*i +: 8]   = 8'b0;
        assign tbl_base[52*i +: 52]  = 52'b0;
      end
    end
  end
endmodule

// File: rtl/tbr_bank_chk.sv
module tbr_bank_chk #(
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = 16,
  parameter int BASE_OFF = 'h100
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_wr,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic [31:0]            bus_rdata,
  input logic                   unit_enable,
  input logic                   unit_quiescent,
  input logic [NUM_REGS-1:0]    tbl_valid,
  input logic [2*NUM_REGS-1:0]  tbl_share,
  input logic [2*NUM_REGS-1:0]  tbl_page,
  input logic [8*NUM_REGS-1:0]  tbl_pages,
  input logic [52*NUM_REGS-1:0] tbl_base
);
  localparam logic [ADDR_W-1:0] LO = ADDR_W'(BASE_OFF);
  localparam logic [ADDR_W-1:0] HI = ADDR_W'(BASE_OFF + 64);

  AST_OUT_OF_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr < LO || bus_addr >= HI || bus_addr[1:0] != 2'b00) |-> bus_rdata == 32'h0); // R1

  AST_TYPE_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == LO + 4) |-> bus_rdata[26:24] == 3'b001); // R3

  AST_LOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (unit_enable || !unit_quiescent)) |=>
      ($stable(tbl_valid) && $stable(tbl_pages) && $stable(tbl_base) && $stable(tbl_page))); // R7

  AST_VALID_RESET: assert property (@(posedge clk)
    !rst_n |=> tbl_valid == '0); // R6

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_fold
    AST_PAGE_FOLDED: assert property (@(posedge clk) disable iff (!rst_n)
      tbl_page[2*g +: 2] != 2'b11); // R5
    AST_SHARE_FOLDED: assert property (@(posedge clk) disable iff (!rst_n)
      tbl_share[2*g +: 2] != 2'b11); // R5
  end
endmodule

bind tbr_bank tbr_bank_chk #(
  .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .BASE_OFF(BASE_OFF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .unit_enable(unit_enable), .unit_quiescent(unit_quiescent),
  .tbl_valid(tbl_valid), .tbl_share(tbl_share), .tbl_page(tbl_page),
  .tbl_pages(tbl_pages), .tbl_base(tbl_base)
);

// File: tb/tbr_bank_tb.sv
module tbr_bank_tb;
  localparam int CLK_P = 10;
  localparam int N     = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, qs = 1'b1;

  logic        a_wr = 1'b0, b_wr = 1'b0;
  logic [15:0] a_addr = '0, b_addr = '0;
  logic [31:0] a_wd = '0, b_wd = '0;
  logic [31:0] a_rd, b_rd;

  logic [N-1:0]    a_valid, a_ind, b_valid, b_ind;
  logic [3*N-1:0]  a_inner, a_outer, b_inner, b_outer;
  logic [2*N-1:0]  a_share, a_page, b_share, b_page;
  logic [8*N-1:0]  a_pages, b_pages;
  logic [52*N-1:0] a_base, b_base;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  tbr_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(a_wr), .bus_addr(a_addr), .bus_wdata(a_wd),
    .bus_rdata(a_rd), .unit_enable(en), .unit_quiescent(qs),
    .tbl_valid(a_valid), .tbl_indirect(a_ind), .tbl_inner(a_inner), .tbl_outer(a_outer),
    .tbl_share(a_share), .tbl_page(a_page), .tbl_pages(a_pages), .tbl_base(a_base));

  tbr_bank #(.VPE_PRESENT(1'b0), .INDIRECT_EN(1'b0), .FIXED_ATTR(1'b1),
             .FIXED_OUTER(3'b011), .FIXED_SHARE(2'b10)) u_dut_tie (
    .clk(clk), .rst_n(rst_n), .bus_wr(b_wr), .bus_addr(b_addr), .bus_wdata(b_wd),
    .bus_rdata(b_rd), .unit_enable(en), .unit_quiescent(qs),
    .tbl_valid(b_valid), .tbl_indirect(b_ind), .tbl_inner(b_inner), .tbl_outer(b_outer),
    .tbl_share(b_share), .tbl_page(b_page), .tbl_pages(b_pages), .tbl_base(b_base));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_a(input logic [15:0] ad, input logic [31:0] d);
    @(negedge clk); a_wr = 1'b1; a_addr = ad; a_wd = d;
    @(negedge clk); a_wr = 1'b0;
  endtask

  task automatic wr_b(input logic [15:0] ad, input logic [31:0] d);
    @(negedge clk); b_wr = 1'b1; b_addr = ad; b_wd = d;
    @(negedge clk); b_wr = 1'b0;
  endtask

  task automatic rd_a(input logic [15:0] ad, output logic [31:0] d);
    @(negedge clk); a_addr = ad; #1 d = a_rd;
  endtask

  task automatic rd_b(input logic [15:0] ad, output logic [31:0] d);
    @(negedge clk); b_addr = ad; #1 d = b_rd;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R6 valid after reset", 64'(a_valid), 64'h0);
    rd_a(16'h104, d);
    chk("R3 reg0 type", 64'(d[26:24]), 64'h1);
    chk("R3 reg0 entry size", 64'(d[20:16]), 64'd7);
    chk("R6 reg0 valid bit", 64'(d[31]), 64'h0);
  endtask

  task automatic t_types();
    logic [31:0] d;
    rd_a(16'h10C, d); chk("R3 reg1 type/esz", 64'(d[26:16]), 64'h40F);
    rd_a(16'h114, d); chk("R3 reg2 type/esz", 64'(d[26:16]), 64'h21F);
    rd_a(16'h11C, d); chk("R4 reg3 upper zero", 64'(d), 64'h0);
  endtask

  task automatic t_halves();
    logic [31:0] d;
    wr_a(16'h100, 32'h1234545A);
    wr_a(16'h104, 32'hC8FF00AB);
    rd_a(16'h104, d); chk("R3 upper with RO fields", 64'(d), 64'hC9E700AB);
    rd_a(16'h100, d); chk("R2 lower kept", 64'(d), 64'h1234545A);
    chk("R10 base 4K", 64'(a_base[51:0]), 64'h00AB12345000);
    chk("R2 outputs", 64'({a_valid[0], a_ind[0], a_outer[2:0], a_share[1:0], a_pages[7:0]}),
        64'({1'b1, 1'b1, 3'd7, 2'b01, 8'h5A}));
  endtask

  task automatic t_fold();
    logic [31:0] d;
    wr_a(16'h100, 32'h00013F03);
    rd_a(16'h100, d); chk("R5 fold readback", 64'(d), 64'h00013203);
    chk("R5 fold outputs", 64'({a_page[1:0], a_share[1:0]}), 64'({2'b10, 2'b00}));
    chk("R10 base 64K", 64'(a_base[51:0]), 64'h300AB00010000);
    rd_a(16'h104, d); chk("R2 upper kept", 64'(d), 64'hC9E700AB);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    en = 1'b1; wr_a(16'h100, 32'hFFFFFFFF);
    rd_a(16'h100, d); chk("R7 enable blocks", 64'(d), 64'h00013203);
    en = 1'b0; qs = 1'b0; wr_a(16'h104, 32'h00000000);
    rd_a(16'h104, d); chk("R7 busy blocks", 64'(d), 64'hC9E700AB);
    chk("R7 valid held", 64'(a_valid[0]), 64'h1);
    qs = 1'b1; wr_a(16'h104, 32'h00000000);
    rd_a(16'h104, d); chk("R7 idle accepts", 64'(d), 64'h01070000);
    chk("R7 valid cleared", 64'(a_valid[0]), 64'h0);
  endtask

  task automatic t_unimpl();
    logic [31:0] d;
    wr_a(16'h118, 32'hFFFFFFFF);
    wr_a(16'h11C, 32'hFFFFFFFF);
    wr_a(16'h138, 32'hFFFFFFFF);
    rd_a(16'h118, d); chk("R4 reg3 lower", 64'(d), 64'h0);
    rd_a(16'h13C, d); chk("R4 reg7 upper", 64'(d), 64'h0);
    chk("R4 outputs 3..7", 64'({a_valid[7:3], a_pages[63:24]}), 64'h0);
  endtask

  task automatic t_window();
    logic [31:0] d;
    wr_a(16'h110, 32'h55555177);
    rd_a(16'h110, d); chk("R1 reg2 lower", 64'(d), 64'h55555177);
    chk("R1 reg2 outputs", 64'({a_page[5:4], a_pages[23:16]}), 64'({2'b01, 8'h77}));
    wr_a(16'h140, 32'hFFFFFFFF);
    wr_a(16'h0F8, 32'hFFFFFFFF);
    wr_a(16'h102, 32'hFFFFFFFF);
    rd_a(16'h100, d); chk("R1 outside write ignored", 64'(d), 64'h00013203);
    rd_a(16'h140, d); chk("R1 read above", 64'(d), 64'h0);
    rd_a(16'h0FC, d); chk("R1 read below", 64'(d), 64'h0);
    rd_a(16'h101, d); chk("R1 unaligned read", 64'(d), 64'h0);
  endtask

  task automatic t_tie();
    logic [31:0] d;
    rd_b(16'h114, d); chk("R4 tie reg2 absent", 64'(d), 64'h0);
    wr_b(16'h104, 32'hFFFFFFFF);
    rd_b(16'h104, d); chk("R8 R9 tied upper", 64'(d), 64'hB967FFFF);
    chk("R8 tied indirect out", 64'(b_ind[0]), 64'h0);
    wr_b(16'h100, 32'h00000C00);
    rd_b(16'h100, d); chk("R9 fixed share", 64'(d), 64'h00000800);
    chk("R9 fixed outputs", 64'({b_outer[2:0], b_share[1:0]}), 64'({3'b011, 2'b10}));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_types();
    t_halves();
    t_fold();
    t_lock();
    t_unimpl();
    t_window();
    t_tie();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule